// File: doc/BRIEF.md
# Bitplane Pixel Serializer with Stretch

This block turns parallel bitplane words into a stream of colour indices, one per pixel clock. A fetch engine upstream gathers one 16-bit word for each of up to eight planes. When the whole group has been fetched, it pulses a group-ready strobe. The serializer keeps the group in a holding register. It moves the group into its shift registers only when the slot counter reaches the transfer point for the current rate mode. The first pixel of the group appears a fixed five slots after that transfer.

When the double-rate mode is selected together with low resolution, every pixel is held for two clock cycles. The picture therefore keeps its normal width. For the same reason, the horizontal position used for sprite comparison is doubled. In every other mode, one pixel is emitted per cycle. A group that arrives while an earlier group is still being shifted waits in the holding register. It takes over at the next 16-pixel boundary without a gap.

Top module: `bitplane_serializer`

## Requirements
- R1: After reset, `pix_vld` is 0 and `pix_idx` is 0.
- R2: A ready group enters the shift registers only in the cycle when `slot` equals 0x40 (`dbl_en`=0) or 0x80 (`dbl_en`=1). A group that becomes ready after that slot has passed is not shown.
- R3: The first pixel of a group is output in the cycle when `slot` equals the transfer point plus 5, which is 0x45 or 0x85.
- R4: Pixels leave each plane word most significant bit first. Bit i of `pix_idx` comes from plane i, and plane i occupies bits [16*i+15:16*i] of `plane_data`.
- R5: Bits of `pix_idx` at positions equal to or above `depth` are 0. A `depth` value above 8 behaves as 8.
- R6: With `dbl_en`=1 and `hires`=0, each pixel is held for two cycles, so one group lasts 32 cycles.
- R7: In every other mode combination, the output advances one pixel per cycle, so one group lasts 16 cycles.
- R8: `spr_x_out` equals `spr_x_in` times two when `dbl_en`=1 and `hires`=0. Otherwise it equals `spr_x_in`.
- R9: While no group is being shown (idle, or between the transfer and the first pixel), `pix_vld` is 0 and `pix_idx` is 0.
- R10: A group that becomes ready while another is shifting does not disturb the current group. Its first pixel follows the last pixel of the current group in the next cycle (or in the next pixel period when stretching).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plane_data | input | 128 | Eight 16-bit plane words, plane i at bits [16*i+15:16*i] |
| grp_done | input | 1 | Pulse: all plane words of a group are present on plane_data |
| slot | input | 9 | Current slot position, one step per clock |
| hires | input | 1 | 1 selects high resolution |
| dbl_en | input | 1 | 1 selects the double-rate mode |
| depth | input | 4 | Number of active planes |
| spr_x_in | input | 9 | Sprite horizontal position before scaling |
| pix_idx | output | 8 | Colour index of the current pixel |
| pix_vld | output | 1 | Current pixel is part of a displayed group |
| spr_x_out | output | 10 | Scaled horizontal position for sprite comparison |

## Verification
The assertions check on every cycle that an invalid pixel carries index zero and that unused plane bits stay zero. They also check that a fresh run of pixels always starts at slot 0x45 or 0x85, that the first stretched pixel is held for a second cycle, and that the sprite position is scaled as the mode requires. Only the bench scenarios can show the actual pixel order and the transfer point when the strobe comes early or late. They also show the seamless handover between back-to-back groups and the exact duration of each pixel across every mode combination.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int NPL = 8;
  localparam int PW  = 16;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } ser_st_e;
endpackage

// File: rtl/bps_hold.sv
module bps_hold #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp_done,
  input  logic [DW-1:0] data_in,
  input  logic          take,
  output logic [DW-1:0] data_out,
  output logic          pend
);
  logic [DW-1:0] data_q;
  logic          pend_q, pend_d;

  always_comb begin
    pend_d = grp_done | (pend_q & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (grp_done) data_q <= data_in;
    end
  end

  assign data_out = data_q;
  assign pend     = pend_q;
endmodule

// File: rtl/bps_ctrl.sv
module bps_ctrl
  import bps_pkg::*;
#(
  parameter int SW        = 9,
  parameter int PWID      = 16,
  parameter int LOAD_NRM  = 'h40,
  parameter int LOAD_DBL  = 'h80,
  parameter int START_DLY = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] slot,
  input  logic          dbl_en,
  input  logic          stretch,
  input  logic          pend,
  output logic          load,
  output logic          shift_en,
  output logic          active
);
  localparam int CW = $clog2(PWID);
  localparam logic [CW-1:0] LAST = CW'(PWID - 1);

  ser_st_e       st_q, st_d;
  logic [CW-1:0] pcnt_q, pcnt_d;
  logic          ph_q, ph_d;
  logic [SW-1:0] lp, go_pt;
  logic          adv, at_end;

  assign lp     = dbl_en ? SW'(LOAD_DBL) : SW'(LOAD_NRM);
  assign go_pt  = lp + SW'(START_DLY - 1);
  assign adv    = stretch ? ph_q : 1'b1;
  assign at_end = (pcnt_q == LAST);

  always_comb begin
    st_d   = st_q;
    pcnt_d = pcnt_q;
    ph_d   = ph_q;
    unique case (st_q)
      ST_IDLE: begin
        if (pend && (slot == lp)) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (slot == go_pt) begin
          st_d   = ST_SHIFT;
          pcnt_d = '0;
          ph_d   = 1'b0;
        end
      end
      ST_SHIFT: begin
        ph_d = stretch ? ~ph_q : 1'b0;
        if (adv) begin
          if (at_end) begin
            pcnt_d = '0;
            if (!pend) st_d = ST_IDLE;
          end else begin
            pcnt_d = pcnt_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pcnt_q <= '0;
      ph_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pcnt_q <= pcnt_d;
      ph_q   <= ph_d;
    end
  end

  assign load     = ((st_q == ST_IDLE) && pend && (slot == lp)) ||
                    ((st_q == ST_SHIFT) && adv && at_end && pend);
  assign shift_en = (st_q == ST_SHIFT) && adv && !at_end;
  assign active   = (st_q == ST_SHIFT);
endmodule

// File: rtl/bps_shifter.sv
module bps_shifter #(
  parameter int NP = 8,
  parameter int PWID = 16,
  parameter int DW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift_en,
  input  logic [NP*PWID-1:0] words,
  input  logic [DW-1:0]      depth,
  output logic [NP-1:0]      msb
);
  for (genvar i = 0; i < NP; i++) begin : g_plane
    logic [PWID-1:0] sr_q, sr_d;
    always_comb begin
      sr_d = sr_q;
      if (load)          sr_d = words[i*PWID +: PWID];
      else if (shift_en) sr_d = {sr_q[PWID-2:0], 1'b0};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
    end
    assign msb[i] = sr_q[PWID-1] & (DW'(i) < depth);
  end
endmodule

// File: rtl/bitplane_serializer.sv
module bitplane_serializer
  import bps_pkg::*;
#(
  parameter int SW = 9,
  parameter int XW = 9,
  parameter int DEPW = $clog2(NPL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPL*PW-1:0]   plane_data,
  input  logic                grp_done,
  input  logic [SW-1:0]       slot,
  input  logic                hires,
  input  logic                dbl_en,
  input  logic [DEPW-1:0]     depth,
  input  logic [XW-1:0]       spr_x_in,
  output logic [NPL-1:0]      pix_idx,
  output logic                pix_vld,
  output logic [XW:0]         spr_x_out
);
  localparam int DW = NPL * PW;

  logic [DW-1:0]  held;
  logic           pend, load, shift_en, active, stretch;
  logic [NPL-1:0] msb;

  assign stretch = dbl_en & ~hires;

  bps_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .grp_done(grp_done), .data_in(plane_data),
    .take(load), .data_out(held), .pend(pend)
  );

  bps_ctrl #(.SW(SW), .PWID(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .slot(slot), .dbl_en(dbl_en), .stretch(stretch),
    .pend(pend), .load(load), .shift_en(shift_en), .active(active)
  );

  bps_shifter #(.NP(NPL), .PWID(PW), .DW(DEPW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
    .words(held), .depth(depth), .msb(msb)
  );

  assign pix_vld   = active;
  assign pix_idx   = active ? msb : '0;
  assign spr_x_out = stretch ? {spr_x_in, 1'b0} : {1'b0, spr_x_in};
endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
  parameter int SW = 9,
  parameter int XW = 9,
  parameter int NP = 8,
  parameter int DEPW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SW-1:0]   slot,
  input logic            hires,
  input logic            dbl_en,
  input logic [DEPW-1:0] depth,
  input logic [XW-1:0]   spr_x_in,
  input logic [XW:0]     spr_x_out,
  input logic [NP-1:0]   pix_idx,
  input logic            pix_vld
);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |-> (pix_idx == '0));

  // R3
  first_pix_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_vld) |-> (slot == (dbl_en ? SW'('h85) : SW'('h45))));

  // R6
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_en && !hires && $rose(pix_vld)) |=> (pix_vld && $stable(pix_idx)));

  // R5
  depth_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth < DEPW'(NP)) |-> ((pix_idx >> depth) == '0));

  // R8
  spr_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_en && !hires) |-> (spr_x_out == ({1'b0, spr_x_in} + {1'b0, spr_x_in})));
endmodule

bind bitplane_serializer bps_checker #(.SW(SW), .XW(XW), .NP(bps_pkg::NPL), .DEPW(DEPW))
  u_chk (.clk(clk), .rst_n(rst_n), .slot(slot), .hires(hires), .dbl_en(dbl_en),
         .depth(depth), .spr_x_in(spr_x_in), .spr_x_out(spr_x_out),
         .pix_idx(pix_idx), .pix_vld(pix_vld));

// File: tb/tb_bitplane_serializer.sv
module tb_bitplane_serializer;
  logic         clk;
  logic         rst_n;
  logic [127:0] plane_data;
  logic         grp_done;
  logic [8:0]   slot;
  logic         hires, dbl_en;
  logic [3:0]   depth;
  logic [8:0]   spr_x_in;
  logic [7:0]   pix_idx;
  logic         pix_vld;
  logic [9:0]   spr_x_out;

  int n_chk = 0;
  int n_bad = 0;

  bitplane_serializer dut (
    .clk(clk), .rst_n(rst_n), .plane_data(plane_data), .grp_done(grp_done),
    .slot(slot), .hires(hires), .dbl_en(dbl_en), .depth(depth),
    .spr_x_in(spr_x_in), .pix_idx(pix_idx), .pix_vld(pix_vld), .spr_x_out(spr_x_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s slot=%0h actual=%0h expected=%0h", req, slot, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; grp_done = 1'b0; slot = '0; plane_data = '0;
    hires = 1'b0; dbl_en = 1'b0; depth = 4'd8; spr_x_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Runs slots 0..last, strobing group g0 at slot d0 and g1 at slot d1 (d1<0: none).
  // ngrp is the number of groups expected on screen.
  task automatic run_scn(input string tag, input bit dbl, input bit hr, input logic [3:0] dep,
                         input logic [127:0] g0, input logic [127:0] g1,
                         input int d0, input int d1, input int ngrp, input int last);
    int per, lp, rel, g, k, eidx, evld;
    logic [127:0] gw;
    do_reset();
    dbl_en = dbl; hires = hr; depth = dep;
    per = (dbl && !hr) ? 2 : 1;
    lp  = dbl ? 'h80 : 'h40;
    for (int s = 0; s <= last; s++) begin
      @(negedge clk);
      slot = 9'(s);
      grp_done = (s == d0) || (s == d1);
      plane_data = (s == d1) ? g1 : g0;
      #1;
      rel = s - (lp + 5);
      evld = 0; eidx = 0;
      if (rel >= 0) begin
        g = rel / (16 * per);
        k = (rel % (16 * per)) / per;
        if (g < ngrp) begin
          evld = 1;
          gw = (g == 0) ? g0 : g1;
          for (int i = 0; i < 8; i++)
            if (i < dep) eidx |= int'(gw[i*16 + 15 - k]) << i;
        end
      end
      chk({tag, " vld R9"}, int'(pix_vld), evld);
      chk({tag, " idx R4"}, int'(pix_idx), eidx);
    end
    grp_done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 vld", int'(pix_vld), 0);
    chk("R1 idx", int'(pix_idx), 0);
  endtask

  task automatic t_sprite();
    do_reset();
    spr_x_in = 9'h0A3;
    dbl_en = 1'b1; hires = 1'b0; #1;
    chk("R8 dbl lo", int'(spr_x_out), 'h146);
    hires = 1'b1; #1;
    chk("R8 dbl hi", int'(spr_x_out), 'h0A3);
    dbl_en = 1'b0; hires = 1'b0; #1;
    chk("R8 normal", int'(spr_x_out), 'h0A3);
    spr_x_in = 9'h1FF; dbl_en = 1'b1; #1;
    chk("R8 max", int'(spr_x_out), 'h3FE);
  endtask

  localparam logic [127:0] PA = 128'h8001_4002_2004_1008_0810_0420_0240_0180;
  localparam logic [127:0] PB = 128'hF0F0_CCCC_AAAA_FF00_1234_5678_9ABC_DEF0;
  localparam logic [127:0] PC = 128'h0F0F_3333_5555_00FF_EDCB_A987_6543_210F;

  initial begin
    t_reset();
    // R2 R3 R7: normal rate, low resolution, early strobe held until 0x40
    run_scn("R2 R3 R7 nrm-lo", 1'b0, 1'b0, 4'd8, PA, '0, 'h10, -1, 1, 'h60);
    // R7: normal rate, high resolution
    run_scn("R7 nrm-hi", 1'b0, 1'b1, 4'd8, PB, '0, 'h20, -1, 1, 'h60);
    // R6: double rate, low resolution stretch
    run_scn("R6 dbl-lo", 1'b1, 1'b0, 4'd8, PB, '0, 'h10, -1, 1, 'hB0);
    // R7: double rate, high resolution, no stretch, load at 0x80
    run_scn("R7 R3 dbl-hi", 1'b1, 1'b1, 4'd8, PC, '0, 'h30, -1, 1, 'hA0);
    // R5: depth masking and over-range depth
    run_scn("R5 depth3", 1'b0, 1'b0, 4'd3, PB, '0, 'h10, -1, 1, 'h58);
    run_scn("R5 depth12", 1'b0, 1'b1, 4'd12, PC, '0, 'h10, -1, 1, 'h58);
    // R10: second group arrives mid-shift
    run_scn("R10 nrm", 1'b0, 1'b0, 4'd8, PB, PC, 'h10, 'h48, 2, 'h70);
    run_scn("R10 dbl-lo", 1'b1, 1'b0, 4'd8, PC, PA, 'h10, 'h90, 2, 'hD0);
    // R2: strobe after the transfer point is never shown
    run_scn("R2 late", 1'b0, 1'b0, 4'd8, PA, '0, 'h42, -1, 0, 'h80);
    t_sprite();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule